// File: doc/BRIEF.md
# Extended-State Save Fault Checker

This block sits in front of the sequencer that writes a processor's extended register state to memory. For each save instruction it decides whether the save may start or which fault must be raised. A one-cycle request pulse presents the effective address, the current operating mode, the feature-supported capability bit, the OS-enable control bit, the task-switched control bit and four decoded prefix flags. One cycle later the block either asserts proceed to the sequencer or asserts fault-valid together with a two-bit fault code.

The checks are the undefined-opcode, device-not-available, alignment and address-range checks. The address-range check covers canonical form in 64-bit mode and the 16-bit address window in real mode. Segment limit, paging and implementation-dependent alignment-check behaviour are handled elsewhere. When several checks fail at once, the fault reported follows a fixed priority.

Top module: `save_fault_checker`

## Requirements
- R1: While reset is high, and in the cycle after it, done, fault_valid, proceed and fault_code are all 0.
- R2: done is 1 in exactly the cycle after a cycle with req high, and 0 otherwise.
- R3: A request with feat_ok = 0 or os_en = 0 yields fault code 1 (undefined opcode).
- R4: A request with any bit of pfx set yields fault code 1. The bits are: bit 0 lock, bit 1 operand-size 66h, bit 2 F3h, bit 3 F2h.
- R5: A request with task_sw = 1 and no undefined-opcode cause yields fault code 2 (device not available).
- R6: A request whose address has any of its low ALIGN_LOG2 bits set yields fault code 3 (general protection) in every mode, when neither of the other two faults applies.
- R7: In 64-bit mode (mode = 2), an address whose bits ADDR_W-1 down to VA_W-1 are not all equal yields fault code 3. In the other modes those bits have no effect on the result.
- R8: In real mode (mode = 0), a request yields fault code 3 when addr + SAVE_BYTES - 1 exceeds REAL_TOP.
- R9: Priority: code 1 overrides code 2, which overrides code 3.
- R10: Codes are 0 none, 1 undefined opcode, 2 device not available, 3 general protection. proceed = done with code 0, and fault_valid = done with a nonzero code. When done is 0, fault_code is 0.
- R11: Mode 1 (protected) and mode 3 (reserved) apply only the alignment rule among the address checks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Check request pulse |
| addr | input | ADDR_W | Effective address of the save area |
| mode | input | 2 | 0 real, 1 protected, 2 64-bit, 3 reserved |
| feat_ok | input | 1 | Save feature supported |
| os_en | input | 1 | OS has enabled the save feature |
| task_sw | input | 1 | Task-switched control bit |
| pfx | input | 4 | Prefix flags: lock, 66h, F3h, F2h |
| done | output | 1 | Decision valid this cycle |
| fault_valid | output | 1 | A fault is reported |
| fault_code | output | 2 | Fault code |
| proceed | output | 1 | Save may start |

## Verification
The bench builds the block with a 16-bit address, a 12-bit virtual address, 8-byte alignment, a 24-byte save area and a real-mode top of 0x0FFF. With these values every one of the 65536 addresses can be issued back to back, with the mode rotated across addresses. This reaches both canonical edges, the last address that fits below the real-mode top and every misalignment. A second sweep crosses all 128 combinations of the control and prefix bits with all four modes at aligned, misaligned and non-canonical addresses, so that every priority pairing occurs.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_NM   = 2'd2,
        FLT_GP   = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        MD_REAL = 2'd0,
        MD_PROT = 2'd1,
        MD_LONG = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        logic ud;
        logic nm;
        logic gp;
    } flt_vec_t;

    localparam int PFX_W = 4;

    // Fixed priority: undefined opcode, then device not available, then protection.
    function automatic flt_e pick_fault(flt_vec_t v);
        if (v.ud)      return FLT_UD;
        else if (v.nm) return FLT_NM;
        else if (v.gp) return FLT_GP;
        else           return FLT_NONE;
    endfunction

endpackage

// File: rtl/sfc_ctl_check.sv
module sfc_ctl_check
    import sfc_pkg::*;
(
    input  logic             feat_ok,
    input  logic             os_en,
    input  logic             task_sw,
    input  logic [PFX_W-1:0] pfx,
    output logic             ud,
    output logic             nm
);
    logic pfx_any;

    always_comb begin
        pfx_any = 1'b0;
        for (int i = 0; i < PFX_W; i++) begin
            pfx_any = pfx_any | pfx[i];
        end
        ud = ~feat_ok | ~os_en | pfx_any;
        nm = task_sw;
    end
endmodule

// File: rtl/sfc_addr_check.sv
module sfc_addr_check
    import sfc_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          VA_W       = 48,
    parameter int          ALIGN_LOG2 = 6,
    parameter int          SAVE_BYTES = 576,
    parameter longint unsigned REAL_TOP = 64'hFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  mode_e             mode,
    output logic              gp
);
    localparam int HI_W = ADDR_W - VA_W + 1;
    localparam logic [ADDR_W:0] SPAN_M1 = (ADDR_W+1)'(SAVE_BYTES - 1);
    localparam logic [ADDR_W:0] TOP_X   = (ADDR_W+1)'(REAL_TOP);

    logic              misaligned;
    logic              canon;
    logic [ADDR_W:0]   last_byte;
    logic              real_over;

    assign misaligned = |addr[ALIGN_LOG2-1:0];

    generate
        if (HI_W > 1) begin : g_canon
            logic [HI_W-1:0] upper;
            assign upper = addr[ADDR_W-1:VA_W-1];
            assign canon = (&upper) | ~(|upper);
        end else begin : g_flat
            assign canon = 1'b1;
        end
    endgenerate

    assign last_byte = {1'b0, addr} + SPAN_M1;
    assign real_over = last_byte > TOP_X;

    always_comb begin
        gp = misaligned;
        unique case (mode)
            MD_LONG: gp = gp | ~canon;
            MD_REAL: gp = gp | real_over;
            default: gp = gp;
        endcase
    end
endmodule

// File: rtl/sfc_result_reg.sv
module sfc_result_reg
    import sfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  flt_vec_t causes,
    output logic     done_q,
    output flt_e     code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            code_q <= FLT_NONE;
        end else begin
            done_q <= req;
            code_q <= req ? pick_fault(causes) : FLT_NONE;
        end
    end
endmodule

// File: rtl/save_fault_checker.sv
module save_fault_checker
    import sfc_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          VA_W       = 48,
    parameter int          ALIGN_LOG2 = 6,
    parameter int          SAVE_BYTES = 576,
    parameter longint unsigned REAL_TOP = 64'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    input  logic              feat_ok,
    input  logic              os_en,
    input  logic              task_sw,
    input  logic [3:0]        pfx,
    output logic              done,
    output logic              fault_valid,
    output logic [1:0]        fault_code,
    output logic              proceed
);
    flt_vec_t causes;
    logic     done_q;
    flt_e     code_q;

    sfc_ctl_check u_ctl (
        .feat_ok (feat_ok),
        .os_en   (os_en),
        .task_sw (task_sw),
        .pfx     (pfx),
        .ud      (causes.ud),
        .nm      (causes.nm)
    );

    sfc_addr_check #(
        .ADDR_W     (ADDR_W),
        .VA_W       (VA_W),
        .ALIGN_LOG2 (ALIGN_LOG2),
        .SAVE_BYTES (SAVE_BYTES),
        .REAL_TOP   (REAL_TOP)
    ) u_addr (
        .addr (addr),
        .mode (mode_e'(mode)),
        .gp   (causes.gp)
    );

    sfc_result_reg u_res (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .causes (causes),
        .done_q (done_q),
        .code_q (code_q)
    );

    assign done        = done_q;
    assign fault_code  = code_q;
    assign fault_valid = done_q & (code_q != FLT_NONE);
    assign proceed     = done_q & (code_q == FLT_NONE);
endmodule

// File: rtl/save_fault_checker_sva.sv
module save_fault_checker_sva #(
    parameter int          ADDR_W     = 64,
    parameter int          VA_W       = 48,
    parameter int          ALIGN_LOG2 = 6,
    parameter int          SAVE_BYTES = 576,
    parameter longint unsigned REAL_TOP = 64'hFFFF
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        mode,
    input logic              feat_ok,
    input logic              os_en,
    input logic              task_sw,
    input logic [3:0]        pfx,
    input logic              done,
    input logic              fault_valid,
    input logic [1:0]        fault_code,
    input logic              proceed
);
    logic no_ud;
    assign no_ud = feat_ok & os_en & ~(|pfx);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done && !fault_valid && !proceed && fault_code == 2'd0)); // R1
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req |=> done); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst) !req |=> !done); // R2
    AST_UD_CTRL: assert property (@(posedge clk) disable iff (rst) (req && (!feat_ok || !os_en)) |=> fault_code == 2'd1); // R3
    AST_UD_PREFIX: assert property (@(posedge clk) disable iff (rst) (req && (|pfx)) |=> fault_code == 2'd1); // R4
    AST_NM_TASK: assert property (@(posedge clk) disable iff (rst) (req && no_ud && task_sw) |=> fault_code == 2'd2); // R5
    AST_GP_ALIGN: assert property (@(posedge clk) disable iff (rst) (req && no_ud && !task_sw && (|addr[ALIGN_LOG2-1:0])) |=> fault_code == 2'd3); // R6
    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst) !(proceed && fault_valid)); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !done |-> (fault_code == 2'd0 && !proceed && !fault_valid)); // R10
endmodule

bind save_fault_checker save_fault_checker_sva #(
    .ADDR_W     (ADDR_W),
    .VA_W       (VA_W),
    .ALIGN_LOG2 (ALIGN_LOG2),
    .SAVE_BYTES (SAVE_BYTES),
    .REAL_TOP   (REAL_TOP)
) u_sva (.*);

// File: tb/save_fault_checker_bench.sv
module save_fault_checker_bench;
    localparam int ADDR_W = 16;
    localparam int VA_W   = 12;
    localparam int ALIGN_LOG2 = 3;
    localparam int SAVE_BYTES = 24;
    localparam longint unsigned REAL_TOP = 64'h0FFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0] mode = 2'd0;
    logic feat_ok = 1'b1, os_en = 1'b1, task_sw = 1'b0;
    logic [3:0] pfx = 4'd0;
    logic done, fault_valid, proceed;
    logic [1:0] fault_code;

    int checks = 0;
    int errors = 0;
    logic pend = 1'b0;
    int exp_code = 0;
    string exp_tag = "R10";

    always #5 clk = ~clk;

    save_fault_checker #(
        .ADDR_W(ADDR_W), .VA_W(VA_W), .ALIGN_LOG2(ALIGN_LOG2),
        .SAVE_BYTES(SAVE_BYTES), .REAL_TOP(REAL_TOP)
    ) u_save_fault_checker (
        .clk(clk), .rst(rst), .req(req), .addr(addr), .mode(mode),
        .feat_ok(feat_ok), .os_en(os_en), .task_sw(task_sw), .pfx(pfx),
        .done(done), .fault_valid(fault_valid), .fault_code(fault_code),
        .proceed(proceed)
    );

    function automatic int model(input int a, input int md, input bit f, input bit o,
                                 input bit t, input int p, output string tag);
        int hi;
        if (!f || !o) begin tag = "R3"; return 1; end
        if (p != 0)   begin tag = "R4"; return 1; end
        if (t)        begin tag = "R5"; return 2; end
        if ((a % (1 << ALIGN_LOG2)) != 0) begin tag = "R6"; return 3; end
        hi = a >> (VA_W - 1);
        if (md == 2 && hi != 0 && hi != (1 << (ADDR_W - VA_W + 1)) - 1) begin tag = "R7"; return 3; end
        if (md == 0 && a + SAVE_BYTES - 1 > int'(REAL_TOP)) begin tag = "R8"; return 3; end
        tag = (md == 1 || md == 3) ? "R11" : "R10";
        return 0;
    endfunction

    task automatic check_now();
        int want_done, want_fv, want_pr, want_code;
        want_done = pend ? 1 : 0;
        want_code = pend ? exp_code : 0;
        want_fv = (pend && exp_code != 0) ? 1 : 0;
        want_pr = (pend && exp_code == 0) ? 1 : 0;
        checks++;
        if (int'(done) != want_done || int'(fault_code) != want_code ||
            int'(fault_valid) != want_fv || int'(proceed) != want_pr) begin
            errors++;
            $display("FAIL %s addr=%h mode=%0d: done=%0d code=%0d fv=%0d pr=%0d expected done=%0d code=%0d fv=%0d pr=%0d",
                     pend ? exp_tag : "R2", addr, mode, done, fault_code, fault_valid, proceed,
                     want_done, want_code, want_fv, want_pr);
        end
    endtask

    // One request per cycle; the result of the previous request is checked first.
    task automatic issue(input int a, input int md, input bit f, input bit o,
                         input bit t, input int p);
        string tg;
        @(negedge clk);
        check_now();
        addr = ADDR_W'(a); mode = 2'(md); feat_ok = f; os_en = o; task_sw = t; pfx = 4'(p);
        req = 1'b1;
        exp_code = model(a, md, f, o, t, p, tg);
        exp_tag = tg;
        pend = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        check_now();
        req = 1'b0;
        pend = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        pend = 1'b0;
        check_now();
        rst = 1'b0;
        req = 1'b0;
        @(negedge clk);
        check_now(); // R1, R2: nothing pending after reset
        idle();      // R2: no request, done low

        // Boundary cases: R8 real-mode window, R7 canonical edges, R11
        issue(16'h0FE8, 0, 1, 1, 0, 0); // R8 last fitting start
        issue(16'h0FF0, 0, 1, 1, 0, 0); // R8 overflow
        issue(16'h07F8, 2, 1, 1, 0, 0); // R7 canonical low top
        issue(16'h0800, 2, 1, 1, 0, 0); // R7 non-canonical
        issue(16'hF800, 2, 1, 1, 0, 0); // R7 canonical high
        issue(16'hF7F8, 2, 1, 1, 0, 0); // R7 non-canonical
        issue(16'h0800, 1, 1, 1, 0, 0); // R11 protected ignores canon
        issue(16'hFFF8, 3, 1, 1, 0, 0); // R11 reserved ignores real window
        issue(16'h0801, 0, 0, 1, 1, 1); // R9 all causes
        issue(16'h0801, 2, 1, 1, 1, 0); // R9 nm over gp
        idle();
        idle();

        // Exhaustive address sweep, mode rotated: R6, R7, R8, R10, R11
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            issue(a, (a ^ (a >> 3) ^ (a >> 11)) & 3, 1, 1, 0, 0);
        end
        idle();

        // Control and prefix cross: R3, R4, R5, R9
        for (int c = 0; c < 128; c++) begin
            for (int md = 0; md < 4; md++) begin
                issue(16'h0040, md, c[0], c[1], c[2], c >> 3);
                issue(16'h0044, md, c[0], c[1], c[2], c >> 3);
                issue(16'h0800, md, c[0], c[1], c[2], c >> 3);
            end
        end
        idle();
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule